// File: doc/BRIEF.md
# Output Overcurrent Shutdown Timer with One-Shot Limit Boost

This block supervises the current-limit comparator of a supply output and decides when that output must be shut down. A sampled flag tells it that the output is sitting at its current limit. A fixed-rate `tick` strobe paces a timer that measures how long the output stays in limit without a break. If the limit condition outlasts the trip time, the block latches a fault and forces the output off. The output then stays off until software clears the fault, whatever the enable request does.

A software control bit can arm a one-shot raised limit. When a limit event begins with the bit set, the block selects a limit 25% above the normal one for the first quarter of the trip time. It then returns to the normal limit and emits a one-cycle pulse that clears the control bit in its register. The raised limit applies again only after software sets the bit again. Both times are counted in ticks and set by parameters, so simulation can use short windows. A build parameter removes the boost logic entirely.

Top module: `ocp_guard`

## Requirements
- R1: While `at_limit` and `en_req` are high and no fault is latched, the block counts `tick` strobes. On the clock edge that samples the TRIP_TICKS-th consecutive tick, `fault` and `out_off` go high and `trip_pulse` is high for exactly one cycle.
- R2: A cycle in which `at_limit` is low resets the tick count to zero. A limit run of fewer than TRIP_TICKS ticks never trips, even when several runs together exceed TRIP_TICKS.
- R3: If `boost_arm` is 1 on the edge where a limit event starts (the limit condition becomes true after a cycle where it was false), `lim_raise` (1 = raised limit, 0 = normal limit) is 1 from the next cycle on.
- R4: An open raised-limit window closes on the edge that samples the QTR_TICKS-th tick of the event. `lim_raise` drops to 0 and `boost_clr` is high for that one cycle.
- R5: If `boost_arm` is 0 when an event starts, `lim_raise` stays 0 for the whole event, even if `boost_arm` is set during that event. The raised limit applies again only at the next event start with `boost_arm` at 1.
- R6: Once `fault` is set, it holds and `out_off` stays 1 whatever `en_req` does, until `fault_clr` is high on a clock edge. From the next cycle on, `fault` is 0.
- R7: After a fault is cleared, with the limit condition still present, a new event starts from a zero count and needs a full TRIP_TICKS ticks to trip again.
- R8: With no fault, `out_off` equals the inverse of `en_req` in the same cycle. A cycle with `en_req` low resets the tick count.
- R9: After reset, `fault`, `trip_pulse`, `lim_raise`, `boost_clr` are 0 and `out_off` equals the inverse of `en_req`.
- R10: If the limit condition ends while a raised-limit window is open, the window closes on that edge, with `lim_raise` to 0 and a one-cycle `boost_clr` pulse.
- R11: With parameter BOOST_EN = 0, `lim_raise` and `boost_clr` stay 0, and tripping behaves as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Fixed-rate timing strobe, one cycle wide |
| at_limit | input | 1 | Sampled flag: output current is at the limit |
| en_req | input | 1 | Output enable request |
| boost_arm | input | 1 | Software control bit that arms the one-shot raised limit |
| fault_clr | input | 1 | Clears the latched fault (after status read) |
| lim_raise | output | 1 | Limit select: 1 = raised by 25%, 0 = normal |
| trip_pulse | output | 1 | One-cycle pulse when the overcurrent trip occurs |
| fault | output | 1 | Latched overcurrent fault |
| out_off | output | 1 | Output disable |
| boost_clr | output | 1 | One-cycle pulse that clears the boost control bit |

## Verification
A tick count that is off by one shows as `trip_pulse` or `boost_clr` landing one tick early or late. The bench sweeps every run length from one tick to past the trip time, with and without boost, so this shows on the first sweep. A count that is not reset between runs shows as a trip after a split run of short bursts, which should never trip. A fault latch that leaks shows as `out_off` following `en_req` while `fault` is still set, on the next edge after `en_req` toggles. A boost window that does not close shows as `lim_raise` staying high past the quarter tick, or as a missing `boost_clr` pulse.

// File: rtl/ocp_guard_pkg.sv
package ocp_guard_pkg;

   // events produced by the limit timer in the current cycle
   typedef struct packed {
      logic quarter_hit;  // tick that completes (or passes) the boost window
      logic trip_hit;     // tick that completes the trip time
   } tmr_evt_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/ocp_limit_timer.sv
module ocp_limit_timer
   import ocp_guard_pkg::*;
#(
   parameter int unsigned TRIP_TICKS = 45000,
   parameter int unsigned QTR_TICKS  = TRIP_TICKS / 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     tick,
   output tmr_evt_t evt
);
   localparam int unsigned CW = cnt_width(TRIP_TICKS);
   localparam logic [CW-1:0] TRIP_CNT  = CW'(TRIP_TICKS);
   localparam logic [CW-1:0] TRIP_LAST = CW'(TRIP_TICKS - 1);
   localparam logic [CW-1:0] QTR_LAST  = CW'(QTR_TICKS - 1);

   logic [CW-1:0] cnt_q;
   logic          step;

   assign step = run & tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != TRIP_CNT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      evt             = '0;
      evt.trip_hit    = step & (cnt_q == TRIP_LAST);
      evt.quarter_hit = step & (cnt_q >= QTR_LAST);
   end

endmodule

// File: rtl/ocp_boost_window.sv
module ocp_boost_window #(
   parameter bit BOOST_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic arm,
   input  logic quarter_hit,
   output logic raise,
   output logic clr_pulse
);
   generate
      if (BOOST_EN) begin : g_boost
         logic run_q;
         logic win_q;
         logic clr_q;
         logic start;
         logic close;

         assign start = run & ~run_q;
         assign close = win_q & (~run | quarter_hit);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= 1'b0;
               win_q <= 1'b0;
               clr_q <= 1'b0;
            end else begin
               run_q <= run;
               clr_q <= close;
               if (start && arm) begin
                  win_q <= 1'b1;
               end else if (close) begin
                  win_q <= 1'b0;
               end
            end
         end

         assign raise     = win_q;
         assign clr_pulse = clr_q;
      end else begin : g_plain
         logic unused_in;
         assign unused_in = ^{clk, rst_n, run, arm, quarter_hit};
         assign raise     = 1'b0;
         assign clr_pulse = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_hit,
   input  logic fault_clr,
   input  logic en_req,
   output logic fault,
   output logic trip_pulse,
   output logic out_off
);
   logic fault_q;
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= trip_hit;
         if (trip_hit) begin
            fault_q <= 1'b1;
         end else if (fault_clr) begin
            fault_q <= 1'b0;
         end
      end
   end

   assign fault      = fault_q;
   assign trip_pulse = pulse_q;
   assign out_off    = fault_q | ~en_req;

endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
   import ocp_guard_pkg::*;
#(
   parameter int unsigned TRIP_TICKS = 45000,
   parameter int unsigned QTR_TICKS  = TRIP_TICKS / 4,
   parameter bit          BOOST_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic at_limit,
   input  logic en_req,
   input  logic boost_arm,
   input  logic fault_clr,
   output logic lim_raise,
   output logic trip_pulse,
   output logic fault,
   output logic out_off,
   output logic boost_clr
);
   generate
      if (TRIP_TICKS < 2) begin : g_bad_trip
         $error("ocp_guard: TRIP_TICKS must be at least 2");
      end
      if ((QTR_TICKS < 1) || (QTR_TICKS >= TRIP_TICKS)) begin : g_bad_qtr
         $error("ocp_guard: QTR_TICKS must lie in 1 .. TRIP_TICKS-1");
      end
   endgenerate

   tmr_evt_t evt;
   logic     run;

   assign run = at_limit & en_req & ~fault;

   ocp_limit_timer #(
      .TRIP_TICKS (TRIP_TICKS),
      .QTR_TICKS  (QTR_TICKS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick),
      .evt   (evt)
   );

   ocp_boost_window #(
      .BOOST_EN (BOOST_EN)
   ) u_boost (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .arm         (boost_arm),
      .quarter_hit (evt.quarter_hit),
      .raise       (lim_raise),
      .clr_pulse   (boost_clr)
   );

   ocp_trip_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .trip_hit   (evt.trip_hit),
      .fault_clr  (fault_clr),
      .en_req     (en_req),
      .fault      (fault),
      .trip_pulse (trip_pulse),
      .out_off    (out_off)
   );

endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic at_limit,
   input logic en_req,
   input logic boost_arm,
   input logic fault_clr,
   input logic lim_raise,
   input logic trip_pulse,
   input logic fault,
   input logic out_off,
   input logic boost_clr
);
   AST_TRIP_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      trip_pulse |-> $past(at_limit & en_req & tick)); // R1

   AST_TRIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trip_pulse |=> !trip_pulse); // R1

   AST_OFF_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> out_off); // R6

   AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !fault_clr) |=> fault); // R6

   AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && fault_clr) |=> !fault); // R6

   AST_RAISE_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      lim_raise |-> $past(at_limit & en_req)); // R3

   AST_RAISE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lim_raise) |-> $past(boost_arm)); // R5

   AST_RAISE_END_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lim_raise) |-> boost_clr); // R4

   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      boost_clr |=> !boost_clr); // R4

   AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault) |-> (out_off == !en_req)); // R8

endmodule

bind ocp_guard ocp_guard_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .at_limit   (at_limit),
   .en_req     (en_req),
   .boost_arm  (boost_arm),
   .fault_clr  (fault_clr),
   .lim_raise  (lim_raise),
   .trip_pulse (trip_pulse),
   .fault      (fault),
   .out_off    (out_off),
   .boost_clr  (boost_clr)
);

// File: tb/ocp_guard_test.sv
module ocp_guard_test;
   localparam int CLK_P = 10;
   localparam int TRIP  = 8;
   localparam int QTR   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, at_limit = 1'b0, en_req = 1'b1, boost_arm = 1'b0, fault_clr = 1'b0;
   logic lim_raise, trip_pulse, fault, out_off, boost_clr;
   logic nb_raise, nb_pulse, nb_fault, nb_off, nb_clr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ocp_guard #(.TRIP_TICKS(TRIP), .QTR_TICKS(QTR), .BOOST_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .at_limit(at_limit), .en_req(en_req),
      .boost_arm(boost_arm), .fault_clr(fault_clr), .lim_raise(lim_raise),
      .trip_pulse(trip_pulse), .fault(fault), .out_off(out_off), .boost_clr(boost_clr));

   ocp_guard #(.TRIP_TICKS(TRIP), .QTR_TICKS(QTR), .BOOST_EN(1'b0)) uut_nb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .at_limit(at_limit), .en_req(en_req),
      .boost_arm(boost_arm), .fault_clr(fault_clr), .lim_raise(nb_raise),
      .trip_pulse(nb_pulse), .fault(nb_fault), .out_off(nb_off), .boost_clr(nb_clr));

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic step_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   // R11: plain variant never raises, trips like the boosted one
   task automatic chk_plain();
      chk("R11 nb lim_raise", nb_raise, 1'b0);
      chk("R11 nb boost_clr", nb_clr, 1'b0);
      chk("R11 nb fault", nb_fault, fault);
      chk("R11 nb trip_pulse", nb_pulse, trip_pulse);
   endtask

   task automatic clear_fault();
      fault_clr = 1'b1;
      @(negedge clk);
      fault_clr = 1'b0;
   endtask

   // one limit event of n ticks, boost armed or not
   task automatic run_event(input int n, input bit armed);
      boost_arm = armed;
      at_limit  = 1'b1;
      @(negedge clk);
      chk(armed ? "R3 raise at start" : "R5 no raise unarmed", lim_raise, armed);
      chk_plain();
      for (int k = 1; k <= n; k++) begin
         step_tick();
         chk("R1 trip_pulse", trip_pulse, k == TRIP);
         chk("R1 fault", fault, k >= TRIP);
         chk("R1 out_off", out_off, k >= TRIP);
         chk("R4 lim_raise", lim_raise, armed && (k < QTR));
         chk("R4 boost_clr", boost_clr, armed && (k == QTR));
         chk_plain();
         if (boost_clr) boost_arm = 1'b0;
      end
      at_limit = 1'b0;
      @(negedge clk);
      chk("R10 boost_clr on early end", boost_clr, armed && (n < QTR));
      chk("R10 lim_raise after end", lim_raise, 1'b0);
      chk("R1 trip_pulse single", trip_pulse, 1'b0);
      if (boost_clr) boost_arm = 1'b0;
      if (n >= TRIP) begin
         en_req = 1'b0;
         @(negedge clk);
         chk("R6 off with en low", out_off, 1'b1);
         en_req = 1'b1;
         @(negedge clk);
         chk("R6 fault held", fault, 1'b1);
         chk("R6 en ignored", out_off, 1'b1);
         clear_fault();
         chk("R6 fault cleared", fault, 1'b0);
         chk("R6 output back on", out_off, 1'b0);
      end else begin
         chk("R2 short run no fault", fault, 1'b0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 fault in reset", fault, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 fault", fault, 1'b0);
      chk("R9 trip_pulse", trip_pulse, 1'b0);
      chk("R9 lim_raise", lim_raise, 1'b0);
      chk("R9 boost_clr", boost_clr, 1'b0);
      chk("R9 out_off", out_off, 1'b0);

      // sweep run length and arming
      for (int a = 0; a < 2; a++)
         for (int n = 1; n <= TRIP + 1; n++)
            run_event(n, a[0]);

      // R2: split runs that sum past the trip time never trip
      at_limit = 1'b1;
      for (int k = 0; k < TRIP - 1; k++) step_tick();
      at_limit = 1'b0;
      @(negedge clk);
      at_limit = 1'b1;
      for (int k = 0; k < TRIP - 1; k++) step_tick();
      chk("R2 split run no trip", fault, 1'b0);

      // R8: enable low resets the count
      en_req = 1'b0;
      #1 chk("R8 out_off follows en", out_off, 1'b1);
      @(negedge clk);
      en_req = 1'b1;
      #1 chk("R8 out_off follows en high", out_off, 1'b0);
      for (int k = 0; k < TRIP - 1; k++) step_tick();
      chk("R8 count reset by enable", fault, 1'b0);
      step_tick();
      chk("R1 trip after full run", fault, 1'b1);

      // R7: clear while limit persists, needs a full run again
      @(negedge clk);
      clear_fault();
      chk("R7 cleared", fault, 1'b0);
      for (int k = 0; k < TRIP - 1; k++) step_tick();
      chk("R7 no early trip", fault, 1'b0);
      step_tick();
      chk("R7 trip after full run", fault, 1'b1);
      at_limit = 1'b0;
      @(negedge clk);
      clear_fault();

      // R5: arming mid-event does not apply; next start does
      boost_arm = 1'b0;
      at_limit  = 1'b1;
      @(negedge clk);
      step_tick();
      boost_arm = 1'b1;
      step_tick();
      chk("R5 mid-event arm ignored", lim_raise, 1'b0);
      step_tick();
      chk("R5 still normal", lim_raise, 1'b0);
      chk("R5 no clr", boost_clr, 1'b0);
      at_limit = 1'b0;
      @(negedge clk);
      at_limit = 1'b1;
      @(negedge clk);
      chk("R5 armed next event", lim_raise, 1'b1);
      at_limit = 1'b0;
      @(negedge clk);
      chk("R10 window cut", boost_clr, 1'b1);
      boost_arm = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule